// File: doc/BRIEF.md
# Clock Page Replacement Selector

This block chooses which physical page frame receives a newly faulted page. It holds one occupancy bit and one reference bit for each of a fixed number of frames, and a hand pointer that walks the frames as a circular list. The surrounding memory manager reports every access to a frame on an access port. It raises a one-cycle fault request when a page must be brought in, then waits for a done pulse that carries the chosen frame index.

While any frame is still unoccupied, the lowest-numbered free frame is handed out at once and the hand stays where it is. Once every frame is occupied, a fault starts a sweep. Each cycle the sweep looks at the frame under the hand. A referenced frame loses its bit and the hand moves on. An unreferenced frame becomes the victim, and the hand steps past it. The frame given out, whether free or evicted, leaves the fault marked as referenced.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset the done strobe is low, every frame is unoccupied and the hand points at frame 0.
- R2: A fault while at least one frame is free returns the lowest-numbered free frame with done one cycle after the request. That frame becomes occupied, and the hand does not move.
- R3: A valid access to an occupied frame sets that frame's reference bit, which spares it from the next sweep that reaches it.
- R4: A fault with all frames occupied and a clear reference bit under the hand returns the hand's frame with done one cycle after the request, and the hand advances by one.
- R5: During a sweep, a frame under the hand whose reference bit is set has the bit cleared and is skipped, and the examination moves to the next frame one cycle later.
- R6: When every reference bit is set, the sweep clears all of them and selects the frame the hand started on, with done N+1 cycles after the request.
- R7: The frame returned by a fault has its reference bit set when done is raised.
- R8: An access to the frame under the hand in the same cycle that frame is examined counts as a reference, so the frame is cleared and skipped rather than chosen.
- R9: Done is a single-cycle pulse, and a fault request raised while a sweep is in progress is ignored.
- R10: The hand wraps from frame N-1 to frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access to frame acc_idx occurs this cycle |
| acc_idx | input | IDXW | Frame index of the access |
| fault_req | input | 1 | One-cycle request for a frame to load a page into |
| done | output | 1 | One-cycle pulse: victim_idx is valid |
| victim_idx | output | IDXW | Frame chosen for the faulting page |

## Verification
The checks assume the requester raises fault_req for one cycle and raises it again only after done has been seen. Under that rule, done cannot appear in two adjacent cycles and a sweep never runs past N busy cycles. The bench's fault task follows this handshake for every request. In one directed case it sends an extra request in the middle of a sweep, at a point where neither property is affected, to show that the request is dropped. Accesses are always given frame indices below N.

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int NFRAMES = 8,
  localparam int IDXW = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  input  logic [IDXW-1:0] acc_idx,
  input  logic            fault_req,
  output logic            done,
  output logic [IDXW-1:0] victim_idx
);

  logic [NFRAMES-1:0] occ_q, ref_q;
  logic [IDXW-1:0]    hand_q, hand_nx, free_idx, victim_q;
  logic               busy_q, done_q;
  logic               has_free, start_free, sweep, hand_hit;

  assign has_free   = ~&occ_q;
  assign start_free = fault_req & ~busy_q & has_free;
  assign sweep      = busy_q | (fault_req & ~has_free);
  assign hand_nx    = (hand_q == IDXW'(NFRAMES - 1)) ? '0 : hand_q + 1'b1;
  assign hand_hit   = ref_q[hand_q] | (acc_valid & (acc_idx == hand_q) & occ_q[hand_q]);

  always_comb begin
    free_idx = '0;
    for (int i = NFRAMES - 1; i >= 0; i--)
      if (!occ_q[i]) free_idx = IDXW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q    <= '0;
      ref_q    <= '0;
      hand_q   <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      victim_q <= '0;
    end else begin
      done_q <= 1'b0;
      for (int i = 0; i < NFRAMES; i++)
        if (acc_valid && acc_idx == IDXW'(i) && occ_q[i]) ref_q[i] <= 1'b1;
      if (start_free) begin
        occ_q[free_idx] <= 1'b1;
        ref_q[free_idx] <= 1'b1;
        victim_q        <= free_idx;
        done_q          <= 1'b1;
      end else if (sweep) begin
        hand_q <= hand_nx;
        if (hand_hit) begin
          ref_q[hand_q] <= 1'b0;
          busy_q        <= 1'b1;
        end else begin
          ref_q[hand_q] <= 1'b1;
          victim_q      <= hand_q;
          done_q        <= 1'b1;
          busy_q        <= 1'b0;
        end
      end
    end
  end

  assign done       = done_q;
  assign victim_idx = victim_q;

endmodule

// File: rtl/clock_victim_sel_chk.sv
module clock_victim_sel_chk #(
  parameter int NFRAMES = 8,
  localparam int IDXW = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               done,
  input logic [IDXW-1:0]    victim_idx,
  input logic [NFRAMES-1:0] occ_q,
  input logic [NFRAMES-1:0] ref_q,
  input logic [IDXW-1:0]    hand_q,
  input logic               busy_q
);

  logic seen_q;
  int   run_q;
  logic [IDXW-1:0] prev_hand_q, prev_step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q      <= 1'b0;
      run_q       <= 0;
      prev_hand_q <= '0;
    end else begin
      seen_q      <= 1'b1;
      run_q       <= busy_q ? run_q + 1 : 0;
      prev_hand_q <= hand_q;
    end
  end

  assign prev_step = (prev_hand_q == IDXW'(NFRAMES - 1)) ? '0 : prev_hand_q + 1'b1;

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_victim_resident_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> occ_q[victim_idx]);

  p_victim_referenced_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ref_q[victim_idx]);

  p_occ_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (($past(occ_q) & ~occ_q) == '0));

  p_hand_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (hand_q == prev_hand_q || hand_q == prev_step));

  p_sweep_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= NFRAMES);

endmodule

bind clock_victim_sel clock_victim_sel_chk #(.NFRAMES(NFRAMES)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .victim_idx(victim_idx),
  .occ_q(occ_q), .ref_q(ref_q), .hand_q(hand_q), .busy_q(busy_q)
);

// File: tb/tb_clock_victim_sel.sv
`timescale 1ns/1ps
module tb_clock_victim_sel;
  localparam int N = 4;
  localparam int W = 2;

  logic clk = 1'b0, rst_n = 1'b0, acc_valid = 1'b0, fault_req = 1'b0;
  logic [W-1:0] acc_idx = '0;
  logic done;
  logic [W-1:0] victim_idx;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  clock_victim_sel #(.NFRAMES(N)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_idx(acc_idx),
    .fault_req(fault_req), .done(done), .victim_idx(victim_idx)
  );

  // {op, idx, expected victim, expected latency}; op 1 = fault, 0 = access
  localparam logic [15:0] VEC [13] = '{
    16'h1001,  // R2 free frame 0
    16'h1011,  // R2 free frame 1
    16'h1021,  // R2 free frame 2
    16'h1031,  // R2 free frame 3, R7 all refs now set
    16'h1005,  // R6 all set: second pass picks frame 0
    16'h1011,  // R4 clear bit under hand
    16'h0300,  // R3 access frame 3
    16'h1021,  // R4 frame 2 unreferenced, frame 3 spared later
    16'h1035,  // R6 from hand 3, R10 wrap to 0
    16'h0100,  // R3 access frame 1
    16'h1001,  // R4 victim 0
    16'h1022,  // R5 skip referenced frame 1
    16'h1013   // R5 skip 3 and 0, R10 wrap
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic access(input int idx);
    @(negedge clk); acc_valid = 1'b1; acc_idx = W'(idx);
    @(negedge clk); acc_valid = 1'b0;
  endtask

  task automatic fault(input int exp_v, input int exp_lat, input int mid_acc, input bit extra_req);
    int lat;
    @(negedge clk); fault_req = 1'b1;
    @(negedge clk); fault_req = 1'b0;
    lat = 1;
    if (!done && mid_acc >= 0) begin acc_valid = 1'b1; acc_idx = W'(mid_acc); end
    while (!done && lat < 20) begin
      @(negedge clk);
      acc_valid = 1'b0;
      if (extra_req && lat == 2) fault_req = 1'b1;
      else fault_req = 1'b0;
      lat++;
    end
    fault_req = 1'b0;
    acc_valid = 1'b0;
    check(victim_idx == W'(exp_v), "R2/R4 victim", int'(victim_idx), exp_v);
    check(lat == exp_lat, "R6 latency", lat, exp_lat);
    @(negedge clk);
    check(done == 1'b0, "R9 done pulse", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done low in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1 done low after reset", int'(done), 0);

    for (int k = 0; k < 13; k++) begin
      if (VEC[k][15:12] == 4'd1)
        fault(int'(VEC[k][7:4]), int'(VEC[k][3:0]), -1, 1'b0);
      else
        access(int'(VEC[k][11:8]));
    end

    // R8: access to frame 3 while it sits under the hand spares it
    fault(0, 3, 3, 1'b0);
    // frame 3 was cleared, frame 1 cleared next, frame 2 chosen
    fault(2, 2, -1, 1'b0);

    // R9: extra request during an all-set sweep is dropped
    access(3);
    access(1);
    fault(3, 5, -1, 1'b1);
    repeat (6) begin
      @(negedge clk);
      check(done == 1'b0, "R9 no second done", int'(done), 0);
    end
    fault(0, 1, -1, 1'b0);  // R4 state intact after ignored request

    // R1: reset frees all frames again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    check(done == 1'b0, "R1 done low in reset", int'(done), 0);
    rst_n = 1'b1;
    fault(0, 1, -1, 1'b0);  // R1 frames free, R2 lowest chosen
    fault(1, 1, -1, 1'b0);  // R2 hand untouched by free handout

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule